// File: doc/BRIEF.md
# Packed Sub-Word Integer ALU

This block is a 64-bit integer datapath that treats each operand as a short vector of packed elements. A two-bit element-size select decides, on every operation, whether the operands hold eight 8-bit, four 16-bit or two 32-bit elements. A single byte-segmented carry chain serves all three sizes: at each byte seam the carry is either passed on or replaced, depending on the selected size. A sign select sets how elements are compared and where saturation clamps them.

The operations are wrapping and clamping add and subtract, element-wise minimum and maximum, and a sum of absolute differences that collapses all elements into one scalar. A narrowing pack turns 16-bit elements from both operands into saturated 8-bit elements. One operation is accepted in any cycle its input strobe is high. The result is registered and appears one cycle later with a valid flag. The asynchronous active-low reset is expected to be released in step with the clock.

Top module: `swar_alu`

## Requirements
- R1: `ew_sel` selects the element size: 0 gives 8-bit, 1 gives 16-bit, 2 gives 32-bit, and 3 behaves exactly like 2. No carry or borrow ever crosses from one element into the next.
- R2: `opcode` 0 (wrapping add) and 2 (wrapping subtract, A minus B) give each element's result modulo 2^n, where n is the element width.
- R3: `opcode` 1 (clamping add) and 3 (clamping subtract) clamp each element result to its range. With `sgn`=1 the range is -2^(n-1) to 2^(n-1)-1. With `sgn`=0 it is 0 to 2^n-1.
- R4: `opcode` 4 returns the smaller and `opcode` 5 the larger of each element pair. Elements are compared as two's-complement when `sgn`=1 and as unsigned when `sgn`=0.
- R5: `opcode` 6 returns the sum over all elements of |A_i - B_i|, with elements read as signed or unsigned per `sgn`. The sum is zero-extended into the 64-bit result.
- R6: `opcode` 7 narrows four 16-bit elements of each operand to 8 bits, whatever `ew_sel` is. The narrowed A elements fill result bytes 0 to 3, and the B elements fill bytes 4 to 7, element k going to byte k. Values outside -128 to 127 (`sgn`=1) or above 255 (`sgn`=0, input read as unsigned) saturate.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` then carries the outcome of that input.
- R8: While `in_valid` is low, `result` keeps its last value, whatever the operand and control inputs do.
- R9: During reset, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| opcode | input | 3 | Operation code (see R2 to R6) |
| ew_sel | input | 2 | Element size select (see R1) |
| sgn | input | 1 | 1: signed elements, 0: unsigned |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Registered result |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath cut into 8-bit lanes. All three element sizes and the aliased fourth code are therefore exercised on one instance. At these sizes, random operands that are biased toward 0x00, 0x7F, 0x80 and 0xFF bytes regularly reach the saturation bounds and the carry seams for every element size. The largest two-element 32-bit absolute-difference sum, which needs 33 bits, is also within reach, so the widest reduction and the zero-extension above it are both checked.

// File: rtl/swar_pkg.sv
package swar_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDS = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBS = 3'd3,
    OP_MIN  = 3'd4,
    OP_MAX  = 3'd5,
    OP_SAD  = 3'd6,
    OP_PACK = 3'd7
  } swar_op_e;

  // Number of base lanes that make up one element for a given size code.
  function automatic int lanes_per_elem(input logic [1:0] ew);
    case (ew)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/swar_seg_adder.sv
// Byte-segmented adder/subtractor; carry restarts at every element seam.
module swar_seg_adder import swar_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic                     sub_i,
  input  logic                     sat_i,
  input  logic                     sgn_i,
  input  logic [1:0]               ew_i,
  output logic [DATA_W-1:0]        res_o,
  output logic [DATA_W/LANE_W-1:0] lt_o
);

  localparam int NB = DATA_W / LANE_W;

  logic [DATA_W-1:0]            bx;
  logic [NB-1:0][LANE_W-1:0]    sum_l;
  logic [NB-1:0]                cy, hi_t, lo_t, lt_t;
  logic                         c_run;
  int                           bpe;

  // Segmented carry chain
  always_comb begin
    bpe   = lanes_per_elem(ew_i);
    bx    = sub_i ? ~b_i : b_i;
    c_run = sub_i;
    for (int i = 0; i < NB; i++) begin
      if ((i % bpe) == 0) c_run = sub_i;
      {c_run, sum_l[i]} = {1'b0, a_i[i*LANE_W +: LANE_W]}
                        + {1'b0, bx[i*LANE_W +: LANE_W]}
                        + {{LANE_W{1'b0}}, c_run};
      cy[i] = c_run;
    end
  end

  // Per-lane bound flags; only the top lane of each element is consumed.
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      logic sa, sb, sr, ovf;
      sa      = a_i[i*LANE_W + LANE_W - 1];
      sb      = bx[i*LANE_W + LANE_W - 1];
      sr      = sum_l[i][LANE_W-1];
      ovf     = (sa == sb) && (sr != sa);
      hi_t[i] = sgn_i ? (ovf & ~sa) : (~sub_i & cy[i]);
      lo_t[i] = sgn_i ? (ovf &  sa) : ( sub_i & ~cy[i]);
      lt_t[i] = sgn_i ? (sr ^ ovf)  : ~cy[i];
    end
  end

  // Broadcast element flags to all its lanes and apply clamping
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      int own;
      own     = i | (bpe - 1);
      lt_o[i] = lt_t[own];
      if (sat_i && hi_t[own])
        res_o[i*LANE_W +: LANE_W] = {~(sgn_i && (i == own)), {(LANE_W-1){1'b1}}};
      else if (sat_i && lo_t[own])
        res_o[i*LANE_W +: LANE_W] = {(sgn_i && (i == own)), {(LANE_W-1){1'b0}}};
      else
        res_o[i*LANE_W +: LANE_W] = sum_l[i];
    end
  end

endmodule

// File: rtl/swar_sad.sv
// Absolute differences per element, reduced to one scalar.
module swar_sad #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]        d_ab_i,
  input  logic [DATA_W-1:0]        d_ba_i,
  input  logic [DATA_W/LANE_W-1:0] lt_ab_i,
  input  logic [DATA_W/LANE_W-1:0] lt_ba_i,
  input  logic [1:0]               ew_i,
  output logic [DATA_W-1:0]        sad_o
);

  localparam int NB = DATA_W / LANE_W;

  logic [DATA_W-1:0] mag;
  logic [DATA_W-1:0] s1, s2, s4;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (lt_ab_i[i])      mag[i*LANE_W +: LANE_W] = d_ba_i[i*LANE_W +: LANE_W];
      else if (lt_ba_i[i]) mag[i*LANE_W +: LANE_W] = d_ab_i[i*LANE_W +: LANE_W];
      else                 mag[i*LANE_W +: LANE_W] = '0;
    end
    s1 = '0;
    s2 = '0;
    s4 = '0;
    for (int e = 0; e < NB; e++)
      s1 = s1 + DATA_W'(mag[e*LANE_W +: LANE_W]);
    for (int e = 0; e < NB/2; e++)
      s2 = s2 + DATA_W'(mag[e*2*LANE_W +: 2*LANE_W]);
    for (int e = 0; e < NB/4; e++)
      s4 = s4 + DATA_W'(mag[e*4*LANE_W +: 4*LANE_W]);
    case (ew_i)
      2'd0:    sad_o = s1;
      2'd1:    sad_o = s2;
      default: sad_o = s4;
    endcase
  end

endmodule

// File: rtl/swar_pack.sv
// Saturating narrow of double-lane elements from both operands.
module swar_pack #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] pk_o
);

  localparam int WIDE = 2 * LANE_W;
  localparam int NE   = DATA_W / WIDE;

  function automatic logic [LANE_W-1:0] narrow(input logic [WIDE-1:0] v, input logic sgn);
    if (sgn) begin
      if ((&v[WIDE-1:LANE_W-1]) || !(|v[WIDE-1:LANE_W-1]))
        return v[LANE_W-1:0];
      else
        return v[WIDE-1] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
    end
    return (|v[WIDE-1:LANE_W]) ? {LANE_W{1'b1}} : v[LANE_W-1:0];
  endfunction

  for (genvar k = 0; k < NE; k++) begin : g_elem
    assign pk_o[k*LANE_W +: LANE_W]      = narrow(a_i[k*WIDE +: WIDE], sgn_i);
    assign pk_o[(NE+k)*LANE_W +: LANE_W] = narrow(b_i[k*WIDE +: WIDE], sgn_i);
  end

endmodule

// File: rtl/swar_alu.sv
module swar_alu import swar_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        opcode,
  input  logic [1:0]        ew_sel,
  input  logic              sgn,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  localparam int NB = DATA_W / LANE_W;

  swar_op_e          op;
  logic              x_sub, x_sat;
  logic [DATA_W-1:0] x_res, y_res, mm_res, sad_res, pk_res, res_d, res_q;
  logic [NB-1:0]     lt_ab, lt_ba;
  logic              valid_q;

  assign op    = swar_op_e'(opcode);
  assign x_sub = !(op == OP_ADD || op == OP_ADDS);
  assign x_sat = (op == OP_ADDS) || (op == OP_SUBS);

  // A op B: add/sub, compare for min/max, first half of |A-B|
  swar_seg_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_fwd (
    .a_i(op_a), .b_i(op_b), .sub_i(x_sub), .sat_i(x_sat), .sgn_i(sgn),
    .ew_i(ew_sel), .res_o(x_res), .lt_o(lt_ab));

  // B - A: second half of |A-B|
  swar_seg_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rev (
    .a_i(op_b), .b_i(op_a), .sub_i(1'b1), .sat_i(1'b0), .sgn_i(sgn),
    .ew_i(ew_sel), .res_o(y_res), .lt_o(lt_ba));

  swar_sad #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_sad (
    .d_ab_i(x_res), .d_ba_i(y_res), .lt_ab_i(lt_ab), .lt_ba_i(lt_ba),
    .ew_i(ew_sel), .sad_o(sad_res));

  swar_pack #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_pack (
    .a_i(op_a), .b_i(op_b), .sgn_i(sgn), .pk_o(pk_res));

  always_comb begin
    for (int i = 0; i < NB; i++)
      mm_res[i*LANE_W +: LANE_W] = (lt_ab[i] ^ (op == OP_MAX)) ? op_a[i*LANE_W +: LANE_W]
                                                               : op_b[i*LANE_W +: LANE_W];
  end

  always_comb begin
    case (op)
      OP_MIN, OP_MAX: res_d = mm_res;
      OP_SAD:         res_d = sad_res;
      OP_PACK:        res_d = pk_res;
      default:        res_d = x_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;

endmodule

// File: rtl/swar_alu_chk.sv
module swar_alu_chk import swar_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [2:0]        opcode,
  input logic [1:0]        ew_sel,
  input logic              sgn,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  localparam int SAD_W = 4*LANE_W + $clog2(DATA_W/(4*LANE_W));

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r5_sad_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SAD) |=> (result[DATA_W-1:SAD_W] == '0));

  a_r4_min_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_MIN && ew_sel == 2'd0 && !sgn) |=>
      (result[LANE_W-1:0] <= $past(op_a[LANE_W-1:0]) &&
       result[LANE_W-1:0] <= $past(op_b[LANE_W-1:0])));

  a_r3_usat_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ADDS && ew_sel == 2'd0 && !sgn) |=>
      (result[LANE_W-1:0] >= $past(op_a[LANE_W-1:0]) &&
       result[LANE_W-1:0] >= $past(op_b[LANE_W-1:0])));

  always @(posedge clk) begin
    if (!rst_n) a_r9_reset_clear: assert (!out_valid && result == '0);
  end

endmodule

bind swar_alu swar_alu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .ew_sel(ew_sel), .sgn(sgn), .out_valid(out_valid),
  .result(result));

// File: tb/test_swar_alu.sv
module test_swar_alu;

  logic        clk, rst_n, in_valid, sgn, out_valid;
  logic [63:0] op_a, op_b, result;
  logic [2:0]  opcode;
  logic [1:0]  ew_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  swar_alu i_swar_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .ew_sel(ew_sel), .sgn(sgn), .out_valid(out_valid),
    .result(result));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_narrow(input logic [15:0] v, input logic s);
    int x;
    x = s ? int'($signed(v)) : int'(v);
    if (s) begin
      if (x > 127)  x = 127;
      if (x < -128) x = -128;
    end else if (x > 255) x = 255;
    return x[7:0];
  endfunction

  function automatic logic [63:0] ref_fn(input logic [63:0] a, input logic [63:0] b,
                                         input logic [2:0] o, input logic [1:0] w,
                                         input logic s);
    logic [63:0] r;
    longint va, vb, vr, lo, hi, mask, sad;
    int n;
    r = '0;
    if (o == 3'd7) begin
      for (int k = 0; k < 4; k++) begin
        r[k*8 +: 8]     = ref_narrow(a[k*16 +: 16], s);
        r[(4+k)*8 +: 8] = ref_narrow(b[k*16 +: 16], s);
      end
      return r;
    end
    n    = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    mask = (longint'(1) << n) - 1;
    lo   = s ? -(longint'(1) << (n-1)) : 0;
    hi   = s ? (longint'(1) << (n-1)) - 1 : mask;
    sad  = 0;
    for (int e = 0; e < 64/n; e++) begin
      va = longint'(a >> (e*n)) & mask;
      vb = longint'(b >> (e*n)) & mask;
      if (s && va[n-1]) va = va - (longint'(1) << n);
      if (s && vb[n-1]) vb = vb - (longint'(1) << n);
      case (o)
        3'd0, 3'd1: vr = va + vb;
        3'd2, 3'd3: vr = va - vb;
        3'd4:       vr = (va < vb) ? va : vb;
        default:    vr = (va > vb) ? va : vb;
      endcase
      if (o == 3'd1 || o == 3'd3) begin
        if (vr > hi) vr = hi;
        if (vr < lo) vr = lo;
      end
      sad = sad + ((va > vb) ? va - vb : vb - va);
      r = r | ((64'(vr) & 64'(mask)) << (e*n));
    end
    if (o == 3'd6) r = 64'(sad);
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd2: return "R2";
      3'd1, 3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      3'd6:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  logic [63:0] last_exp;

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [2:0] o,
                        input logic [1:0] w, input logic s, input string tag);
    op_a = a; op_b = b; opcode = o; ew_sel = w; sgn = s; in_valid = 1'b1;
    last_exp = ref_fn(a, b, o, w, s);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid", {63'd0, out_valid}, 64'd1);
    chk(tag, result, last_exp);
  endtask

  function automatic logic [63:0] pick_operand();
    logic [63:0] v;
    case ($urandom % 4)
      0: for (int k = 0; k < 8; k++) begin
           case ($urandom % 4)
             0: v[k*8 +: 8] = 8'h00;
             1: v[k*8 +: 8] = 8'h7F;
             2: v[k*8 +: 8] = 8'h80;
             default: v[k*8 +: 8] = 8'hFF;
           endcase
         end
      1: v = {56'd0, 8'($urandom)} << (8 * ($urandom % 8));
      default: v = {32'($urandom), 32'($urandom)};
    endcase
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    opcode = '0; ew_sel = '0; sgn = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", {63'd0, out_valid}, 64'd0);
    chk("R9 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 carries stop at element seams for every size
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 3'd0, 2'd0, 1'b0, "R1 add8 seam");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 3'd0, 2'd1, 1'b0, "R1 add16 seam");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd2, 1'b0, "R1 add32 seam");
    run_op(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 3'd2, 2'd3, 1'b0, "R1 code3 sub32");
    run_op(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 3'd2, 2'd0, 1'b0, "R2 sub8 wrap");
    // R3 clamps
    run_op(64'h7F7F_8080_F0F0_0000, 64'h0101_FFFF_2020_0000, 3'd1, 2'd0, 1'b1, "R3 sadd8");
    run_op(64'h00F0_00F0_00F0_00F0, 64'h0020_0020_0020_0020, 3'd1, 2'd0, 1'b0, "R3 uadd8");
    run_op(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 3'd3, 2'd2, 1'b1, "R3 ssub32");
    run_op(64'h0005_0005_0005_0005, 64'h0009_0001_0009_0001, 3'd3, 2'd1, 1'b0, "R3 usub16");
    // R4
    run_op(64'h80FF_7F00_0102_0304, 64'h7F00_80FF_0403_0201, 3'd4, 2'd0, 1'b1, "R4 smin8");
    run_op(64'h80FF_7F00_0102_0304, 64'h7F00_80FF_0403_0201, 3'd5, 2'd0, 1'b0, "R4 umax8");
    // R5
    run_op(64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 2'd0, 1'b0, "R5 usad8");
    run_op(64'h7FFF_FFFF_7FFF_FFFF, 64'h8000_0000_8000_0000, 3'd6, 2'd2, 1'b1, "R5 ssad32");
    // R6 ignores ew_sel
    run_op(64'h0100_FF00_0042_FF80, 64'h0080_7FFF_8000_0001, 3'd7, 2'd1, 1'b1, "R6 spack");
    run_op(64'h0100_FF00_0042_FF80, 64'h0080_7FFF_8000_0001, 3'd7, 2'd3, 1'b0, "R6 upack");

    // R8 hold while idle
    op_a = ~op_a; op_b = ~op_b; opcode = 3'd0; ew_sel = 2'd0; sgn = ~sgn;
    @(negedge clk);
    chk("R8 valid low", {63'd0, out_valid}, 64'd0);
    chk("R8 hold", result, last_exp);

    for (int it = 0; it < 3000; it++) begin
      logic [2:0] o;
      o = 3'($urandom);
      run_op(pick_operand(), pick_operand(), o, 2'($urandom), 1'($urandom), req_of(o));
      if ((it % 200) == 0) begin
        op_a = pick_operand(); op_b = pick_operand(); opcode = 3'($urandom);
        @(negedge clk);
        chk("R8 idle hold", result, last_exp);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule